// File: doc/BRIEF.md
# PCM Time-Slot Serial Gate

This block picks one 8-bit receive slot and one 8-bit transmit slot out of a frame-synchronous PCM bit stream. The system clock is the external bit clock, so each clock cycle is one bit period. A one-cycle frame-sync pulse restarts a frame position counter. The frame is 32 or 64 slots long, which is 256 or 512 bit periods. Each direction has its own slot number from 0 to 63 and its own 3-bit delay code. Together these place that direction's slot relative to the sync pulse.

The serial data path uses three outputs: a receive strobe that marks the bits to accept, a transmit strobe that marks the bits that consume a data bit from the framer, and the serial transmit line. An open-drain-style slot indicator pin is pulled low for the whole transmit slot. A companion enable output shows when that pin is driven. A reduced-capacity mode carries only seven data bits per slot. In that mode the eighth received bit is ignored and the eighth transmitted bit is sent as 1.

Top module: `pcm_slot_gate`

## Requirements
- R1: While `rst_n` is low, and in the first bit period after it is released, the frame position is 0. With slot 5 selected for both directions and delay code 7, `rx_en`, `tx_take` and `tx_ind_oe` are 0 and `txd` is 1.
- R2: A selected slot covers eight consecutive bit periods. With delay code 7 it covers frame positions slot*8 to slot*8+7. Frame position p is the p-th bit period after the one in which `fsync` was sampled high; the period right after that edge is position 0.
- R3: A delay code c postpones its slot by (c+1) mod 8 bit periods. Code 7 means no delay and code 0 means one period. With no delay, slot 0 starts at position 0.
- R4: Without `fsync`, the position wraps from 511 to 0 when `frame64`=1, and from 255 to 0 when `frame64`=0.
- R5: `fsync` sampled high at any position restarts the frame, so the next period is position 0. This lets frames of other lengths be used.
- R6: When `frame64`=0, slot numbers 32 to 63 never select any bit period.
- R7: A delayed last slot of the frame wraps across the frame boundary. Its final bits fall at the first positions of the next frame.
- R8: `rx_en` is 1 exactly in the bit periods of the receive slot. When `mode56`=1, the eighth bit of the slot (bit index 7) is excluded.
- R9: During a transmit-slot data bit, `txd` equals `tx_data`. Outside the transmit slot, `txd` is 1.
- R10: When `mode56`=1, `tx_take` is 0 and `txd` is 1 in the eighth bit period of the transmit slot. `tx_take` is 1 in the other seven.
- R11: `tx_ind_oe` is 1 for all eight transmit-slot bit periods in both modes. During those periods `tx_ind_n` is driven to 0; otherwise `tx_ind_n` is released to high impedance.
- R12: The receive and transmit slot placements are independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one cycle per bit period |
| rst_n | input | 1 | Active-low reset |
| fsync | input | 1 | Frame-sync pulse; the next period is frame position 0 |
| frame64 | input | 1 | 1: 64-slot frame, 0: 32-slot frame |
| mode56 | input | 1 | 1: seven data bits per slot |
| rx_slot | input | 6 | Receive slot number |
| rx_delay | input | 3 | Receive delay code, (code+1) mod 8 periods |
| tx_slot | input | 6 | Transmit slot number |
| tx_delay | input | 3 | Transmit delay code, (code+1) mod 8 periods |
| tx_data | input | 1 | Next transmit bit from the framer |
| rx_en | output | 1 | Receive bit strobe |
| tx_take | output | 1 | Transmit bit consumed this period |
| txd | output | 1 | Serial transmit line |
| tx_ind_oe | output | 1 | Transmit-slot indicator is being driven |
| tx_ind_n | output | 1 | Transmit-slot indicator: 0 in slot, high impedance otherwise |

## Verification
The bench targets the delay arithmetic at its edges. If code 7 were not mapped to zero delay, every slot would be off by one period. If the last slot did not wrap, its final bits would be lost or would land at positions 511 or 255 of the wrong frame. In 32-slot mode, slot numbers above 31 must stay silent; a design that ignored the mode would alias them onto low slots or onto the tail of the 512-period count. The reduced-capacity bit must be handled separately per direction. A design that dropped the indicator in that bit, or still consumed a data bit there, would shorten the indicator window or shift the framer's data by one bit each frame. Early and repeated sync pulses check that the restart beats the natural wrap.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
  localparam int IDX_W   = 3;               // bits per slot = 2**IDX_W
  localparam int SLOT_W  = 6;               // up to 64 slots
  localparam int SHIFT_W = IDX_W;           // delay stays within one slot
  localparam int POS_W   = SLOT_W + IDX_W;  // frame position width

  typedef logic [POS_W-1:0]   pos_t;
  typedef logic [SLOT_W-1:0]  slot_t;
  typedef logic [SHIFT_W-1:0] code_t;
  typedef logic [IDX_W-1:0]   idx_t;

  typedef struct packed {
    logic hit;
    idx_t idx;
  } slot_hit_t;

  // Delay code to delay in bit periods: the all-ones code means none.
  function automatic code_t delay_of(input code_t code);
    code_t d;
    d = code + code_t'(1);
    return d;
  endfunction

  // Place a frame position relative to a delayed slot.
  function automatic slot_hit_t locate(input pos_t pos, input code_t code,
                                       input logic long_frame, input slot_t slot);
    slot_hit_t r;
    pos_t      rel;
    rel = pos - pos_t'(delay_of(code));
    if (!long_frame) rel[POS_W-1] = 1'b0;   // modulo the short frame
    r.hit = (rel[POS_W-1:IDX_W] == slot);
    r.idx = rel[IDX_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/pcm_frame_counter.sv
module pcm_frame_counter
  import pcm_slot_pkg::*;
#(
  parameter int PW = POS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fsync,
  input  logic          long_frame,
  output logic [PW-1:0] pos
);
  localparam logic [PW-1:0] LONG_LAST  = {PW{1'b1}};
  localparam logic [PW-1:0] SHORT_LAST = {1'b0, {(PW-1){1'b1}}};

  logic [PW-1:0] last;
  logic          at_end;

  assign last   = long_frame ? LONG_LAST : SHORT_LAST;
  assign at_end = (pos == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pos <= '0;
    else if (fsync || at_end) pos <= '0;
    else                      pos <= pos + 1'b1;
  end
endmodule

// File: rtl/pcm_slot_match.sv
module pcm_slot_match
  import pcm_slot_pkg::*;
(
  input  pos_t  pos,
  input  logic  long_frame,
  input  slot_t slot,
  input  code_t code,
  input  logic  drop_last,
  output logic  in_slot,
  output logic  data_bit,
  output idx_t  idx
);
  localparam idx_t LAST_IDX = {IDX_W{1'b1}};

  slot_hit_t h;

  assign h        = locate(pos, code, long_frame, slot);
  assign in_slot  = h.hit;
  assign idx      = h.idx;
  assign data_bit = h.hit && !(drop_last && (h.idx == LAST_IDX));
endmodule

// File: rtl/pcm_tx_shaper.sv
module pcm_tx_shaper (
  input  logic in_slot,
  input  logic data_bit,
  input  logic tx_data,
  output logic txd,
  output logic ind_oe,
  output wire  ind_n
);
  // Mark ones outside the slot and in the stuffed eighth bit.
  assign txd    = data_bit ? tx_data : 1'b1;
  assign ind_oe = in_slot;
  assign ind_n  = in_slot ? 1'b0 : 1'bz;
endmodule

// File: rtl/pcm_slot_gate.sv
module pcm_slot_gate
  import pcm_slot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic              frame64,
  input  logic              mode56,
  input  logic [SLOT_W-1:0] rx_slot,
  input  logic [SHIFT_W-1:0] rx_delay,
  input  logic [SLOT_W-1:0] tx_slot,
  input  logic [SHIFT_W-1:0] tx_delay,
  input  logic              tx_data,
  output logic              rx_en,
  output logic              tx_take,
  output logic              txd,
  output logic              tx_ind_oe,
  output wire               tx_ind_n
);
  pos_t frame_pos;
  logic rx_in_slot, tx_in_slot;
  idx_t rx_idx, tx_idx;

  pcm_frame_counter #(.PW(POS_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .fsync(fsync),
    .long_frame(frame64), .pos(frame_pos)
  );

  pcm_slot_match u_rx (
    .pos(frame_pos), .long_frame(frame64), .slot(rx_slot), .code(rx_delay),
    .drop_last(mode56), .in_slot(rx_in_slot), .data_bit(rx_en), .idx(rx_idx)
  );

  pcm_slot_match u_tx (
    .pos(frame_pos), .long_frame(frame64), .slot(tx_slot), .code(tx_delay),
    .drop_last(mode56), .in_slot(tx_in_slot), .data_bit(tx_take), .idx(tx_idx)
  );

  pcm_tx_shaper u_shape (
    .in_slot(tx_in_slot), .data_bit(tx_take), .tx_data(tx_data),
    .txd(txd), .ind_oe(tx_ind_oe), .ind_n(tx_ind_n)
  );
endmodule

// File: rtl/pcm_slot_gate_chk.sv
module pcm_slot_gate_chk
  import pcm_slot_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic fsync,
  input logic frame64,
  input pos_t pos,
  input logic tx_data,
  input logic tx_take,
  input logic txd,
  input logic tx_ind_oe,
  input logic tx_ind_n
);
  localparam pos_t SHORT_END = {1'b0, {(POS_W-1){1'b1}}};

  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> pos == '0);

  p_wrap_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsync && !frame64 && pos == SHORT_END) |=> pos == '0);

  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsync && pos < SHORT_END) |=> pos == $past(pos) + 1'b1);

  p_idle_mark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ind_oe |-> txd);

  p_pass_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> txd == tx_data);

  p_take_in_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> tx_ind_oe);

  p_stuff_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ind_oe && !tx_take) |-> txd);

  p_ind_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ind_oe |-> !tx_ind_n);
endmodule

bind pcm_slot_gate pcm_slot_gate_chk i_chk (
  .clk(clk), .rst_n(rst_n), .fsync(fsync), .frame64(frame64), .pos(frame_pos),
  .tx_data(tx_data), .tx_take(tx_take), .txd(txd),
  .tx_ind_oe(tx_ind_oe), .tx_ind_n(tx_ind_n)
);

// File: tb/test_pcm_slot_gate.sv
`timescale 1ns/100ps
module test_pcm_slot_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fsync = 1'b0, frame64 = 1'b1, mode56 = 1'b0, tx_data = 1'b0;
  logic [5:0] rx_slot = 6'd5, tx_slot = 6'd5;
  logic [2:0] rx_delay = 3'd7, tx_delay = 3'd7;
  logic rx_en, tx_take, txd, tx_ind_oe;
  wire  tx_ind_n;

  int total = 0;
  int bad = 0;
  int ref_pos = 0;

  always #2.5 clk = ~clk;

  pcm_slot_gate i_pcm_slot_gate (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .frame64(frame64), .mode56(mode56),
    .rx_slot(rx_slot), .rx_delay(rx_delay), .tx_slot(tx_slot), .tx_delay(tx_delay),
    .tx_data(tx_data), .rx_en(rx_en), .tx_take(tx_take), .txd(txd),
    .tx_ind_oe(tx_ind_oe), .tx_ind_n(tx_ind_n)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s pos=%0d act=%0d exp=%0d", tag, what, ref_pos, act, exp);
    end
  endtask

  // Independent placement model: frame length L, delay (code+1) mod 8.
  function automatic int rel_of(input int p, input int code);
    int len = frame64 ? 512 : 256;
    int d = (code + 1) % 8;
    return (p - d + len) % len;
  endfunction

  task automatic check_now(input string tag);
    int rr = rel_of(ref_pos, rx_delay);
    int rt = rel_of(ref_pos, tx_delay);
    bit hr = (rr / 8) == rx_slot;
    bit ht = (rt / 8) == tx_slot;
    bit er = hr && !(mode56 && (rr % 8) == 7);
    bit et = ht && !(mode56 && (rt % 8) == 7);
    chk(tag, "rx_en", rx_en, er);
    chk(tag, "tx_take", tx_take, et);
    chk(tag, "tx_ind_oe", tx_ind_oe, ht);
    chk(tag, "txd", txd, et ? tx_data : 1);
    if (ht) chk(tag, "tx_ind_n", tx_ind_n, 0);
  endtask

  task automatic step(input bit fs, input string tag);
    int len = frame64 ? 512 : 256;
    fsync = fs;
    @(posedge clk); #1;
    fsync = 1'b0;
    ref_pos = fs ? 0 : ((ref_pos >= len - 1) ? 0 : ref_pos + 1);
    tx_data = ref_pos[0] ^ ref_pos[2] ^ ref_pos[5];
    #1;
    check_now(tag);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, tag);
  endtask

  task automatic t_reset;
    // R1: outputs idle while in reset and at position 0 after release
    #1;
    chk("R1", "rx_en", rx_en, 0);
    chk("R1", "txd", txd, 1);
    chk("R1", "tx_ind_oe", tx_ind_oe, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    ref_pos = 0;
    #1;
    check_now("R1");
    run(60, "R1");
  endtask

  task automatic t_basic;
    frame64 = 1; mode56 = 0;
    rx_slot = 3; rx_delay = 7; tx_slot = 10; tx_delay = 7;
    step(1'b1, "R2/R12");
    run(200, "R2/R8/R9/R12");
    rx_slot = 0; tx_slot = 0;
    step(1'b1, "R3 slot0");
    run(20, "R3 slot0");
  endtask

  task automatic t_delay;
    frame64 = 1;
    rx_slot = 4; rx_delay = 0; tx_slot = 4; tx_delay = 4;
    step(1'b1, "R3");
    run(120, "R3/R12");
  endtask

  task automatic t_short_wrap;
    frame64 = 0;
    rx_slot = 31; rx_delay = 7; tx_slot = 1; tx_delay = 2;
    step(1'b1, "R4");
    run(600, "R4");
  endtask

  task automatic t_high_slot;
    frame64 = 0;
    rx_slot = 40; rx_delay = 3; tx_slot = 32; tx_delay = 7;
    step(1'b1, "R6");
    run(300, "R6");
  endtask

  task automatic t_last_wrap;
    frame64 = 1;
    tx_slot = 63; tx_delay = 2; rx_slot = 63; rx_delay = 6;
    step(1'b1, "R7");
    run(1030, "R7/R4");
  endtask

  task automatic t_resync;
    frame64 = 1;
    rx_slot = 0; rx_delay = 7; tx_slot = 36; tx_delay = 1;
    for (int k = 0; k < 3; k++) begin
      step(1'b1, "R5");
      run(300, "R5");
    end
  endtask

  task automatic t_mode56;
    frame64 = 1; mode56 = 1;
    rx_slot = 2; rx_delay = 7; tx_slot = 7; tx_delay = 5;
    step(1'b1, "R10");
    run(120, "R8/R10/R11");
    mode56 = 0;
    step(1'b1, "R11");
    run(120, "R11");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_delay();
    t_short_wrap();
    t_high_slot();
    t_last_wrap();
    t_resync();
    t_mode56();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R1 act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule